// File: doc/BRIEF.md
# PWM Integrate-and-Hold Timing Sequencer

This block produces the three control signals for a synchronous integrate-and-hold demodulator that turns a pulse-width-modulated train into a DC level within one period. It runs a fixed-length period counter and generates a PWM pulse whose high time follows a duty input. From that pulse it derives a sample strobe, which tells the external hold stage to capture the integrator voltage. It also derives a discharge control, which shorts the integrator capacitor back to zero.

Each period follows a fixed order. The sequencer starts in state `ST_DISCHARGE`, where the integrator is held at zero. At the period start it moves to `ST_INTEGRATE`, where the PWM is high and the discharge switch is open. This transition is named *start*, and it is skipped when the duty is zero. When the high time runs out it moves to `ST_SAMPLE`; this transition is named *capture*, and in that state the strobe is high and the switch is still open. When the strobe length has elapsed it returns to `ST_DISCHARGE`; this transition is named *dump*. A period start that comes while the duty is zero is named *skip* and keeps the state in `ST_DISCHARGE`.

The strobe lasts ten microseconds, and the `CYC_PER_US` parameter sets how many clock cycles that is. The period length is set by `PERIOD_CYC`.

Top module: `pwmih_seq`

## Requirements
- R1: While `rst_n` is low, and on the cycle it goes low, the outputs are `pwm_o`=0, `sample_o`=0 and `discharge_o`=1.
- R2: A period is exactly `PERIOD_CYC` clock cycles. For a duty d with 0 < d ≤ `PERIOD_CYC`−10·`CYC_PER_US`, `pwm_o` is high for the first d cycles of the period and low for the rest.
- R3: `sample_o` is high for exactly 10·`CYC_PER_US` cycles. Those cycles start in the cycle right after `pwm_o` falls.
- R4: In every cycle exactly one of `pwm_o`, `sample_o` and `discharge_o` is high. As a result, `discharge_o` drops in the same cycle that `pwm_o` rises, and it returns high only after the strobe has ended.
- R5: `duty_i` is sampled only at the period boundary. A change of `duty_i` in the middle of a period has no effect on that period's outputs.
- R6: A duty of 0 gives a period with no PWM pulse and no strobe. In that period `discharge_o` stays high for all `PERIOD_CYC` cycles.
- R7: A duty above `PERIOD_CYC`−10·`CYC_PER_US` is clamped to that value, so the strobe always ends within the period.
- R8: The first period starts on the first clock edge after `rst_n` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_i | input | $clog2(PERIOD_CYC+1) | High time in clock cycles, sampled at the period start |
| pwm_o | output | 1 | PWM pulse (registered) |
| sample_o | output | 1 | Hold-capture strobe (registered) |
| discharge_o | output | 1 | 1 = integrator switch closed, capacitor discharged (registered) |

## Verification
The assertions check on every cycle the following properties:
- the three outputs are mutually exclusive;
- a strobe follows every PWM fall and rises only after PWM was high;
- the switch opens only into a PWM pulse;
- every strobe run has the exact ten-microsecond length;
- no pulse exceeds the clamped maximum.

Other behaviours can only be shown by the bench's scenarios:
- the exact period length;
- that the high time matches the duty;
- that a duty change in mid-period is ignored;
- the zero-duty period;
- the start of the first period right after reset.

The bench checks these by comparing every cycle of whole periods against a computed waveform.

// File: rtl/pwmih_pkg.sv
`timescale 1ns/1ps
package pwmih_pkg;
    // Sequencer phase within one PWM period
    typedef enum logic [1:0] {
        ST_DISCHARGE = 2'd0,
        ST_INTEGRATE = 2'd1,
        ST_SAMPLE    = 2'd2
    } seq_state_t;
endpackage

// File: rtl/pwmih_period_ctr.sv
`timescale 1ns/1ps
module pwmih_period_ctr #(
    parameter int PERIOD_CYC = 50000,
    parameter int CW         = $clog2(PERIOD_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    output logic wrap_o
);
    localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

    logic [CW-1:0] pos_q;

    // Starts at the last position so the first edge after reset opens a period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= LAST;
        end else if (pos_q == LAST) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
        end
    end

    assign wrap_o = (pos_q == LAST);
endmodule

// File: rtl/pwmih_dncnt.sv
`timescale 1ns/1ps
module pwmih_dncnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pwmih_fsm.sv
`timescale 1ns/1ps
module pwmih_fsm
    import pwmih_pkg::*;
#(
    parameter int PERIOD_CYC = 50000,
    parameter int STB_LEN    = 500,
    parameter int CW         = $clog2(PERIOD_CYC + 1),
    parameter int SW         = $clog2(STB_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wrap_i,
    input  logic [CW-1:0] duty_i,
    input  logic          hi_zero_i,
    input  logic          stb_zero_i,
    output logic          hi_load_o,
    output logic [CW-1:0] hi_val_o,
    output logic          stb_load_o,
    output logic [SW-1:0] stb_val_o,
    output logic          pwm_o,
    output logic          sample_o,
    output logic          discharge_o
);
    localparam logic [CW-1:0] MAX_HI = CW'(PERIOD_CYC - STB_LEN);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] duty_c;

    // Clamp keeps the strobe inside the period
    assign duty_c    = (duty_i > MAX_HI) ? MAX_HI : duty_i;
    assign hi_val_o  = duty_c - 1'b1;
    assign stb_val_o = SW'(STB_LEN - 1);

    // Next state: the period boundary takes priority over every phase
    always_comb begin
        state_d    = state_q;
        hi_load_o  = 1'b0;
        stb_load_o = 1'b0;
        if (wrap_i) begin
            if (duty_c != '0) begin
                state_d   = ST_INTEGRATE;   // start
                hi_load_o = 1'b1;
            end else begin
                state_d   = ST_DISCHARGE;   // skip
            end
        end else begin
            unique case (state_q)
                ST_INTEGRATE: begin
                    if (hi_zero_i) begin
                        state_d    = ST_SAMPLE; // capture
                        stb_load_o = 1'b1;
                    end
                end
                ST_SAMPLE: begin
                    if (stb_zero_i) begin
                        state_d = ST_DISCHARGE; // dump
                    end
                end
                ST_DISCHARGE: state_d = ST_DISCHARGE;
                default:      state_d = ST_DISCHARGE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DISCHARGE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_o       <= 1'b0;
            sample_o    <= 1'b0;
            discharge_o <= 1'b1;
        end else begin
            pwm_o       <= (state_d == ST_INTEGRATE);
            sample_o    <= (state_d == ST_SAMPLE);
            discharge_o <= (state_d == ST_DISCHARGE);
        end
    end
endmodule

// File: rtl/pwmih_seq.sv
`timescale 1ns/1ps
module pwmih_seq #(
    parameter int PERIOD_CYC = 50000,
    parameter int CYC_PER_US = 50,
    parameter int CW         = $clog2(PERIOD_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] duty_i,
    output logic          pwm_o,
    output logic          sample_o,
    output logic          discharge_o
);
    localparam int STB_LEN = 10 * CYC_PER_US;
    localparam int SW      = $clog2(STB_LEN + 1);

    logic          wrap;
    logic          hi_load, hi_zero;
    logic [CW-1:0] hi_val;
    logic          stb_load, stb_zero;
    logic [SW-1:0] stb_val;

    pwmih_period_ctr #(.PERIOD_CYC(PERIOD_CYC), .CW(CW)) u_period (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap_o (wrap)
    );

    pwmih_dncnt #(.W(CW)) u_hi_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (hi_load),
        .val_i  (hi_val),
        .zero_o (hi_zero)
    );

    pwmih_dncnt #(.W(SW)) u_stb_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (stb_load),
        .val_i  (stb_val),
        .zero_o (stb_zero)
    );

    pwmih_fsm #(
        .PERIOD_CYC (PERIOD_CYC),
        .STB_LEN    (STB_LEN),
        .CW         (CW),
        .SW         (SW)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wrap_i      (wrap),
        .duty_i      (duty_i),
        .hi_zero_i   (hi_zero),
        .stb_zero_i  (stb_zero),
        .hi_load_o   (hi_load),
        .hi_val_o    (hi_val),
        .stb_load_o  (stb_load),
        .stb_val_o   (stb_val),
        .pwm_o       (pwm_o),
        .sample_o    (sample_o),
        .discharge_o (discharge_o)
    );
endmodule

// File: rtl/pwmih_chk.sv
`timescale 1ns/1ps
module pwmih_chk #(
    parameter int PERIOD_CYC = 50000,
    parameter int CYC_PER_US = 50
) (
    input logic clk,
    input logic rst_n,
    input logic pwm_o,
    input logic sample_o,
    input logic discharge_o
);
    localparam int STB_LEN = 10 * CYC_PER_US;
    localparam int MAX_HI  = PERIOD_CYC - STB_LEN;

    int unsigned stb_run_q;
    int unsigned pwm_run_q;

    // Lengths of the current high runs, counted in cycles already seen
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_run_q <= 0;
            pwm_run_q <= 0;
        end else begin
            stb_run_q <= sample_o ? stb_run_q + 1 : 0;
            pwm_run_q <= pwm_o ? pwm_run_q + 1 : 0;
        end
    end

    a_r4_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({pwm_o, sample_o, discharge_o}));

    a_r3_strobe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_o) |-> sample_o);

    a_r3_strobe_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_o) |-> $past(pwm_o));

    a_r3_strobe_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sample_o) |-> (stb_run_q == STB_LEN));

    a_r4_open_into_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(discharge_o) |-> pwm_o);

    a_r7_pulse_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_o |-> (pwm_run_q < MAX_HI));
endmodule

bind pwmih_seq pwmih_chk #(
    .PERIOD_CYC (PERIOD_CYC),
    .CYC_PER_US (CYC_PER_US)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwm_o       (pwm_o),
    .sample_o    (sample_o),
    .discharge_o (discharge_o)
);

// File: tb/tb_pwmih_seq.sv
`timescale 1ns/1ps
module tb_pwmih_seq;
    localparam int P      = 60;
    localparam int CPU    = 2;
    localparam int STB    = 10 * CPU;
    localparam int MAXHI  = P - STB;
    localparam int CW     = $clog2(P + 1);
    localparam int NV     = 9;
    // duty input, expected high time
    localparam int VEC_DUTY [NV] = '{1, 10, 25, 39, 40, 41, 60, 63, 0};
    localparam int VEC_EXP  [NV] = '{1, 10, 25, 39, 40, 40, 40, 40, 0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] duty_i = '0;
    logic          pwm_o, sample_o, discharge_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pwmih_seq #(.PERIOD_CYC(P), .CYC_PER_US(CPU)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .duty_i      (duty_i),
        .pwm_o       (pwm_o),
        .sample_o    (sample_o),
        .discharge_o (discharge_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Compare one whole period, starting at the edge that opens it.
    // duty_i is disturbed mid-period to show it is ignored (R5).
    task automatic run_period(input int de, input string tag);
        int bad = 0;
        int first = -1;
        int hi_cnt = 0;
        int act_w = 0;
        int exp_w = 0;
        for (int j = 0; j < P; j++) begin
            bit ep, es, ed;
            @(posedge clk);
            @(negedge clk);
            ep = (j < de);
            es = (de > 0) && (j >= de) && (j < de + STB);
            ed = !(ep || es);
            if (pwm_o) hi_cnt++;
            if ({pwm_o, sample_o, discharge_o} != {ep, es, ed}) begin
                bad++;
                if (first < 0) begin
                    first = j;
                    act_w = {pwm_o, sample_o, discharge_o};
                    exp_w = {ep, es, ed};
                end
            end
            if (j == P / 2) duty_i = CW'(13);
        end
        chk(bad == 0, {tag, " waveform {pwm,smp,dis} first bad cycle"}, act_w, exp_w);
        if (bad != 0) $display("     at cycle %0d of period, %0d bad cycles", first, bad);
        chk(hi_cnt == de, {tag, " high-time count"}, hi_cnt, de);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({pwm_o, sample_o, discharge_o} == 3'b001, "R1 reset outputs",
            {pwm_o, sample_o, discharge_o}, 1);

        // Vector table; reset released at the same negedge as the first duty (R8)
        rst_n = 1'b1;
        for (int v = 0; v < NV; v++) begin
            string tag;
            duty_i = CW'(VEC_DUTY[v]);
            if (VEC_EXP[v] == 0)             tag = "R6 R5";
            else if (VEC_DUTY[v] > MAXHI)    tag = "R7 R3 R5";
            else if (v == 0)                 tag = "R8 R2 R3 R4";
            else                             tag = "R2 R3 R4 R5";
            run_period(VEC_EXP[v], tag);
        end

        // Directed: reset in the middle of a pulse (R1)
        duty_i = CW'(30);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk({pwm_o, sample_o, discharge_o} == 3'b001, "R1 mid-run reset",
            {pwm_o, sample_o, discharge_o}, 1);
        repeat (2) @(negedge clk);

        // Directed: first period right after release (R8), short duty
        duty_i = CW'(5);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(pwm_o == 1'b1 && discharge_o == 1'b0, "R8 pulse on first edge",
            {pwm_o, discharge_o}, 2);
        // remaining period: cycles 1..P-1 with duty 5
        begin
            int bad = 0;
            for (int j = 1; j < P; j++) begin
                @(posedge clk);
                @(negedge clk);
                if ({pwm_o, sample_o, discharge_o} !=
                    {j < 5, (j >= 5) && (j < 5 + STB), !(j < 5 + STB)}) bad++;
            end
            chk(bad == 0, "R3 R4 post-reset period bad cycles", bad, 0);
        end
        // Next period repeats with the same duty (R2 fixed period)
        run_period(5, "R2 periodic repeat");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule